// File: doc/BRIEF.md
# Dual-Width Memory Read/Write Aligner

This block sits between the data registers of a processor datapath and a memory system made of two banks of different widths: a 16-bit bank and a 24-bit bank. Accesses arrive over one of two paths, a narrow 16-bit path and a wide 24-bit path. The path an access uses does not decide which bank answers. The block compares the access address against a programmable boundary. Addresses at or above the boundary fall in the 24-bit bank, and lower addresses fall in the 16-bit bank. Either path can therefore reach either bank.

On a read, the block takes the raw memory word and returns the 16-bit value destined for a data register. It also keeps an 8-bit extension register, which holds the low byte of a full 24-bit transfer. On a write, it places the 16-bit register value into the proper bits of the memory word. When the access is a full 24-bit transfer, it fills the low byte from the extension register. Address generation and bus arbitration are handled elsewhere.

The memory word is always carried on a 24-bit lane. A 16-bit bank presents its data on lane bits 23:8.

Top module: `dw_mem_aligner`

## Requirements
- R1: While reset is asserted, and right after it, `reg_rvalid` is 0, `reg_rdata` is 0 and `ext_value` is 0. The boundary returns to its reset value, 0x8000.
- R2: `mem_wide_bank` is 1 when `acc_addr` is greater than or equal to the current boundary, and 0 otherwise. The output is combinational, and an address equal to the boundary counts as wide.
- R3: One clock edge after a read is accepted (`acc_valid`=1, `acc_write`=0), `reg_rvalid` is 1 and `reg_rdata` equals `mem_rdata[23:8]`. This holds for every path and bank combination. `reg_rdata` keeps its value until the next read.
- R4: A read on the wide path (`acc_wide_bus`=1) that targets the wide bank loads `ext_value` with `mem_rdata[7:0]` at the next edge.
- R5: A read on the wide path that targets the narrow bank clears `ext_value` to 0 at the next edge.
- R6: An access on the narrow path (`acc_wide_bus`=0), read or write, leaves `ext_value` unchanged. Writes on the wide path also leave it unchanged.
- R7: During an accepted write, `mem_wdata[23:8]` equals `reg_wdata`, and `reg_rvalid` is 0 after the edge. When no write is being made, `mem_wdata` is 0.
- R8: During a write on the wide path to the wide bank, `mem_wdata[7:0]` equals `ext_value`. During any other write, `mem_wdata[7:0]` is 0.
- R9: A pulse on `bnd_we` loads `bnd_value` into the boundary at the clock edge. An access presented in the same cycle is classified with the old boundary, and the new boundary applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wide_bus | input | 1 | 1 = wide 24-bit path, 0 = narrow 16-bit path |
| acc_addr | input | 16 | Access address |
| mem_rdata | input | 24 | Raw memory word on the 24-bit lane |
| reg_wdata | input | 16 | Register value to be written |
| bnd_we | input | 1 | Load the bank boundary |
| bnd_value | input | 16 | New bank boundary |
| mem_wide_bank | output | 1 | Address falls in the 24-bit bank |
| mem_wdata | output | 24 | Aligned memory write word |
| reg_rdata | output | 16 | Aligned register read value |
| reg_rvalid | output | 1 | `reg_rdata` updated by the last edge |
| ext_value | output | 8 | Extension register |

## Verification
Two functions can act in the same cycle: a boundary update and the classification of an access. The bench provokes this by pulsing `bnd_we` with a new, lower boundary while a wide-path read targets an address that lies between the new boundary and the old one. During that cycle `mem_wide_bank` is expected to be 0, and `ext_value` is expected to be cleared rather than loaded. In the next cycle the same address is expected to decode as wide, and a read there loads the extension register. A second such pair checks that a wide-path write uses the extension value captured by the read before it, and that a narrow-path access between them leaves that value unchanged.

// File: rtl/dwa_pkg.sv
package dwa_pkg;

  typedef enum logic {
    PATH_NARROW = 1'b0,
    PATH_WIDE   = 1'b1
  } path_e;

  typedef struct packed {
    logic  valid;
    logic  write;
    path_e path;
    logic  wide_bank;
  } acc_cls_t;

  function automatic logic is_wide_read(acc_cls_t c);
    return c.valid && !c.write && (c.path == PATH_WIDE);
  endfunction

  function automatic logic is_full_write(acc_cls_t c);
    return c.valid && c.write && (c.path == PATH_WIDE) && c.wide_bank;
  endfunction

endpackage

// File: rtl/dwa_bank_decode.sv
module dwa_bank_decode #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BND_RESET = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bnd_we,
  input  logic [ADDR_W-1:0] bnd_value,
  input  logic [ADDR_W-1:0] addr,
  output logic              wide_bank
);

  localparam logic [ADDR_W-1:0] RESET_V = ADDR_W'(BND_RESET);

  logic [ADDR_W-1:0] boundary_q;

  function automatic logic in_wide_region(logic [ADDR_W-1:0] a,
                                          logic [ADDR_W-1:0] b);
    return a >= b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      boundary_q <= RESET_V;
    else if (bnd_we) boundary_q <= bnd_value;
  end

  assign wide_bank = in_wide_region(addr, boundary_q);

endmodule

// File: rtl/dwa_read_align.sv
module dwa_read_align #(
  parameter int NARROW_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_fire,
  input  logic [NARROW_W-1:0] word_hi,
  output logic [NARROW_W-1:0] reg_rdata,
  output logic                reg_rvalid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= rd_fire;
      if (rd_fire) reg_rdata <= word_hi;
    end
  end

endmodule

// File: rtl/dwa_ext_track.sv
module dwa_ext_track
  import dwa_pkg::*;
#(
  parameter int EXT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  acc_cls_t         cls,
  input  logic [EXT_W-1:0] word_lo,
  output logic [EXT_W-1:0] ext_q,
  output logic             ev_capture,
  output logic             ev_clear
);

  assign ev_capture = is_wide_read(cls) &&  cls.wide_bank;
  assign ev_clear   = is_wide_read(cls) && !cls.wide_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ext_q <= '0;
    else if (ev_capture) ext_q <= word_lo;
    else if (ev_clear)   ext_q <= '0;
  end

endmodule

// File: rtl/dwa_write_align.sv
module dwa_write_align
  import dwa_pkg::*;
#(
  parameter int NARROW_W = 16,
  parameter int EXT_W    = 8
) (
  input  acc_cls_t                  cls,
  input  logic [NARROW_W-1:0]       reg_wdata,
  input  logic [EXT_W-1:0]          ext_q,
  output logic [NARROW_W+EXT_W-1:0] mem_wdata,
  output logic                      ev_full_write
);

  function automatic logic [NARROW_W+EXT_W-1:0] pack_word(
      logic [NARROW_W-1:0] hi, logic [EXT_W-1:0] lo);
    return {hi, lo};
  endfunction

  assign ev_full_write = is_full_write(cls);

  always_comb begin
    mem_wdata = '0;
    if (cls.valid && cls.write)
      mem_wdata = pack_word(reg_wdata, ev_full_write ? ext_q : '0);
  end

endmodule

// File: rtl/dw_mem_aligner.sv
module dw_mem_aligner
  import dwa_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          NARROW_W  = 16,
  parameter int          WIDE_W    = 24,
  parameter logic [15:0] BND_RESET = 16'h8000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic                acc_wide_bus,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic [WIDE_W-1:0]   mem_rdata,
  input  logic [NARROW_W-1:0] reg_wdata,
  input  logic                bnd_we,
  input  logic [ADDR_W-1:0]   bnd_value,
  output logic                mem_wide_bank,
  output logic [WIDE_W-1:0]   mem_wdata,
  output logic [NARROW_W-1:0] reg_rdata,
  output logic                reg_rvalid,
  output logic [WIDE_W-NARROW_W-1:0] ext_value
);

  localparam int EXT_W = WIDE_W - NARROW_W;

  acc_cls_t cls;
  logic     wide_bank;
  logic     ev_read_fire;
  logic     ev_ext_capture;
  logic     ev_ext_clear;
  logic     ev_full_write;

  dwa_bank_decode #(.ADDR_W(ADDR_W), .BND_RESET(BND_RESET)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .bnd_we    (bnd_we),
    .bnd_value (bnd_value),
    .addr      (acc_addr),
    .wide_bank (wide_bank)
  );

  always_comb begin
    cls.valid     = acc_valid;
    cls.write     = acc_write;
    cls.path      = acc_wide_bus ? PATH_WIDE : PATH_NARROW;
    cls.wide_bank = wide_bank;
  end

  assign ev_read_fire  = acc_valid && !acc_write;
  assign mem_wide_bank = wide_bank;

  dwa_read_align #(.NARROW_W(NARROW_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_fire    (ev_read_fire),
    .word_hi    (mem_rdata[WIDE_W-1:EXT_W]),
    .reg_rdata  (reg_rdata),
    .reg_rvalid (reg_rvalid)
  );

  dwa_ext_track #(.EXT_W(EXT_W)) u_ext (
    .clk        (clk),
    .rst_n      (rst_n),
    .cls        (cls),
    .word_lo    (mem_rdata[EXT_W-1:0]),
    .ext_q      (ext_value),
    .ev_capture (ev_ext_capture),
    .ev_clear   (ev_ext_clear)
  );

  dwa_write_align #(.NARROW_W(NARROW_W), .EXT_W(EXT_W)) u_wr (
    .cls           (cls),
    .reg_wdata     (reg_wdata),
    .ext_q         (ext_value),
    .mem_wdata     (mem_wdata),
    .ev_full_write (ev_full_write)
  );

endmodule

// File: rtl/dwa_checker.sv
module dwa_checker #(
  parameter int ADDR_W   = 16,
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 24
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       acc_valid,
  input logic                       acc_write,
  input logic                       acc_wide_bus,
  input logic [ADDR_W-1:0]          acc_addr,
  input logic [WIDE_W-1:0]          mem_rdata,
  input logic [NARROW_W-1:0]        reg_wdata,
  input logic                       bnd_we,
  input logic [ADDR_W-1:0]          bnd_value,
  input logic                       mem_wide_bank,
  input logic [WIDE_W-1:0]          mem_wdata,
  input logic [NARROW_W-1:0]        reg_rdata,
  input logic                       reg_rvalid,
  input logic [WIDE_W-NARROW_W-1:0] ext_value,
  input logic                       ev_ext_capture,
  input logic                       ev_ext_clear,
  input logic                       ev_full_write
);

  localparam int EXT_W = WIDE_W - NARROW_W;

  a_r3_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> reg_rvalid);

  a_r3_read_data: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write) |=> reg_rdata == $past(mem_rdata[WIDE_W-1:EXT_W]));

  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ext_capture |=> ext_value == $past(mem_rdata[EXT_W-1:0]));

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ext_clear |=> ext_value == '0);

  a_r5_clear_only_narrow_bank: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ext_clear |-> !mem_wide_bank && acc_wide_bus);

  a_r6_ext_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_write && acc_wide_bus) |=> $stable(ext_value));

  a_r7_write_no_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write) |=> !reg_rvalid);

  a_r7_write_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write) |-> mem_wdata[WIDE_W-1:EXT_W] == reg_wdata);

  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_write) |-> mem_wdata == '0);

  a_r8_full_low: assert property (@(posedge clk) disable iff (!rst_n)
    ev_full_write |-> mem_wdata[EXT_W-1:0] == ext_value);

  a_r8_part_low: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !(acc_wide_bus && mem_wide_bank))
      |-> mem_wdata[EXT_W-1:0] == '0);

  a_r9_new_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_we |=> mem_wide_bank == (acc_addr >= $past(bnd_value)));

endmodule

bind dw_mem_aligner dwa_checker #(
  .ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .WIDE_W(WIDE_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .acc_valid      (acc_valid),
  .acc_write      (acc_write),
  .acc_wide_bus   (acc_wide_bus),
  .acc_addr       (acc_addr),
  .mem_rdata      (mem_rdata),
  .reg_wdata      (reg_wdata),
  .bnd_we         (bnd_we),
  .bnd_value      (bnd_value),
  .mem_wide_bank  (mem_wide_bank),
  .mem_wdata      (mem_wdata),
  .reg_rdata      (reg_rdata),
  .reg_rvalid     (reg_rvalid),
  .ext_value      (ext_value),
  .ev_ext_capture (ev_ext_capture),
  .ev_ext_clear   (ev_ext_clear),
  .ev_full_write  (ev_full_write)
);

// File: tb/sim_dw_mem_aligner.sv
module sim_dw_mem_aligner;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic        acc_wide_bus = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [23:0] mem_rdata = '0;
  logic [15:0] reg_wdata = '0;
  logic        bnd_we = 1'b0;
  logic [15:0] bnd_value = '0;
  logic        mem_wide_bank;
  logic [23:0] mem_wdata;
  logic [15:0] reg_rdata;
  logic        reg_rvalid;
  logic [7:0]  ext_value;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] m_bnd   = 16'h8000;
  logic [7:0]  m_ext   = '0;
  logic [15:0] m_rdata = '0;

  always #10 clk = ~clk;

  dw_mem_aligner u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_wide_bus(acc_wide_bus), .acc_addr(acc_addr), .mem_rdata(mem_rdata),
    .reg_wdata(reg_wdata), .bnd_we(bnd_we), .bnd_value(bnd_value),
    .mem_wide_bank(mem_wide_bank), .mem_wdata(mem_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .ext_value(ext_value)
  );

  // {write, wide path, addr, memory word, register write value}
  localparam logic [57:0] VEC [8] = '{
    {1'b0, 1'b0, 16'h1000, 24'hABCD12, 16'h0000},
    {1'b0, 1'b1, 16'h9000, 24'h3456F7, 16'h0000},
    {1'b0, 1'b0, 16'hA000, 24'h778899, 16'h0000},
    {1'b1, 1'b1, 16'h8000, 24'h000000, 16'h1234},
    {1'b1, 1'b0, 16'hFFFF, 24'h000000, 16'hBEEF},
    {1'b1, 1'b1, 16'h7FFF, 24'h000000, 16'h0101},
    {1'b0, 1'b1, 16'h0004, 24'h5A5AC3, 16'h0000},
    {1'b0, 1'b1, 16'hC000, 24'h00FF80, 16'h0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Presents one access at a falling edge, checks combinational outputs,
  // then checks registered outputs at the following falling edge.
  task automatic access(input logic w, input logic wide, input logic [15:0] a,
                        input logic [23:0] rd, input logic [15:0] wd,
                        input logic bwe, input logic [15:0] bval);
    logic        wbank;
    logic [23:0] exp_w;
    acc_valid = 1'b1; acc_write = w; acc_wide_bus = wide; acc_addr = a;
    mem_rdata = rd; reg_wdata = wd; bnd_we = bwe; bnd_value = bval;
    #2;
    wbank = (a >= m_bnd);
    chk("R2/R9 bank decode", {31'd0, mem_wide_bank}, {31'd0, wbank});
    if (w) begin
      exp_w = {wd, (wide && wbank) ? m_ext : 8'h00};
      chk("R7/R8 write word", {8'd0, mem_wdata}, {8'd0, exp_w});
    end
    @(posedge clk);
    if (!w) begin
      m_rdata = rd[23:8];
      if (wide) m_ext = wbank ? rd[7:0] : 8'h00;
    end
    if (bwe) m_bnd = bval;
    @(negedge clk);
    chk("R3/R7 rvalid", {31'd0, reg_rvalid}, {31'd0, !w});
    chk("R3 read data", {16'd0, reg_rdata}, {16'd0, m_rdata});
    chk("R4/R5/R6 ext", {24'd0, ext_value}, {24'd0, m_ext});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rvalid in reset", {31'd0, reg_rvalid}, 32'd0);
    chk("R1 ext in reset", {24'd0, ext_value}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata after reset", {16'd0, reg_rdata}, 32'd0);
    acc_addr = 16'h7FFF; #1;
    chk("R1 R2 below boundary", {31'd0, mem_wide_bank}, 32'd0);
    acc_addr = 16'h8000; #1;
    chk("R1 R2 at boundary", {31'd0, mem_wide_bank}, 32'd1);
    chk("R7 idle write word", {8'd0, mem_wdata}, 32'd0);

    for (int i = 0; i < 8; i++) begin
      access(VEC[i][57], VEC[i][56], VEC[i][55:40], VEC[i][39:16], VEC[i][15:0],
             1'b0, 16'h0);
    end

    // R9: boundary lowered in the same cycle as a wide read between old and new
    access(1'b0, 1'b1, 16'h4000, 24'h1111AA, 16'h0, 1'b1, 16'h2000);
    chk("R9 R5 old boundary cleared ext", {24'd0, ext_value}, 32'd0);
    access(1'b0, 1'b1, 16'h4000, 24'h2222BB, 16'h0, 1'b0, 16'h0);
    chk("R9 R4 new boundary captured", {24'd0, ext_value}, 32'hBB);
    // R6: narrow write between capture and full write
    access(1'b1, 1'b0, 16'h5000, 24'h0, 16'hCAFE, 1'b0, 16'h0);
    access(1'b1, 1'b1, 16'h6000, 24'h0, 16'h0F0F, 1'b0, 16'h0);

    // R1: reset mid-run restores boundary and clears state
    acc_valid = 1'b0; acc_write = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    m_bnd = 16'h8000; m_ext = '0; m_rdata = '0;
    chk("R1 ext after second reset", {24'd0, ext_value}, 32'd0);
    chk("R1 rdata after second reset", {16'd0, reg_rdata}, 32'd0);
    rst_n = 1'b1;
    acc_addr = 16'h4000; #1;
    chk("R1 boundary restored", {31'd0, mem_wide_bank}, 32'd0);
    @(negedge clk);
    chk("R3 no read no rvalid", {31'd0, reg_rvalid}, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule